// File: doc/BRIEF.md
# Trap and System-Call Entry State Builder

This block is pure combinational logic. When the pipeline takes a trap or a system call, it produces four results: the machine-state word the core switches to, the two save/restore words that keep the interrupted context, and the address fetch resumes from. The issuing stage supplies these inputs:

- the current machine-state word;
- the address of the current instruction;
- a five-bit trap-kind vector;
- a trap vector number;
- the seven-bit privilege-level field of the system-call instruction;
- a select bit that chooses between trap and system call;
- a strobe that says whether an entry is taken this cycle.

Each result has its own valid flag. The flags go high together whenever the strobe is high.

Bit numbers in this brief are big-endian: bit 0 is the most significant bit. Big-endian bit n sits at LSB-0 position 63−n. Every position below also gives its LSB-0 index in brackets. The block changes the machine-state word with a fixed clear-and-set pattern. It moves the transactional-state field from suspended to a special value. It encodes the trap cause into reserved bits of the saved state word.

Top module: `trap_entry_update`

## Requirements
- R1: While `op_valid` is 0, `msr_ok`, `srr0_ok`, `srr1_ok` and `nia_ok` are all 0.
- R2: While `op_valid` is 1, all four valid flags are 1, for both the trap select (`op_is_sc`=0) and the system-call select (`op_is_sc`=1).
- R3: The new state word starts as a copy of `msr_in` with these changes:
  - cleared: BE 58 [5], 59 [4], 52 [11], 55 [8], 48 [15], 62 [1], 31 [32], 38 [25], 40 [23], 49 [14], 50 [13], 61 [2], 53–54 [10:9] and 5 [58];
  - set to 1: BE 0 [63] and 63 [0];
  - copied from `msr_in`: every bit not named in R3, R4 or R9.
- R4: The transactional-state field is BE 29–30 [34:33]. If it holds 0b10 in `msr_in`, the output field is 0b01. Any other value passes through unchanged.
- R5: For a trap, `srr0_out` equals `cia_in`. For a system call, it equals `cia_in` + 4 modulo 2^64.
- R6: For a trap, `srr1_out` is `msr_in` with these changes:
  - BE 32–35 [31:28] cleared;
  - BE 46 [17] set to 1 exactly when `trap_kind` is zero;
  - BE 45 [18] = `trap_kind`[1];
  - BE 43 [20] = `trap_kind`[0];
  - BE 47 [16] = `trap_kind`[3];
  - BE 44 [19] = `trap_kind`[4];
  - BE 42 [21] = 0;
  - `trap_kind`[2] has no effect.
- R7: For a trap, `nia_out` is `trap_vec` shifted left by 4, zero-extended to 64 bits.
- R8: For a system call, `srr1_out` clears BE 33–36 [30:27] and BE 42–47 [21:16]. All other bits (BE 0–32, 37–41, 48–63) are copied from `msr_in`.
- R9: The hypervisor bit is BE 3 [60]. For a system call it is set to 1 when `sc_level` equals 1 and cleared otherwise. For a trap it is copied from `msr_in`.
- R10: For a system call, `nia_out` is the fixed entry address `SC_ENTRY` (default 0xC00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_valid | input | 1 | An entry is taken this cycle |
| op_is_sc | input | 1 | 1 = system call, 0 = trap |
| msr_in | input | 64 | Current machine-state word |
| cia_in | input | 64 | Current instruction address |
| trap_kind | input | 5 | Trap-kind vector |
| trap_vec | input | VEC_W (12) | Trap vector number |
| sc_level | input | 7 | System-call level field |
| msr_out | output | 64 | New machine-state word |
| msr_ok | output | 1 | `msr_out` valid |
| srr0_out | output | 64 | Saved return address |
| srr0_ok | output | 1 | `srr0_out` valid |
| srr1_out | output | 64 | Saved state word |
| srr1_ok | output | 1 | `srr1_out` valid |
| nia_out | output | 64 | Next instruction address |
| nia_ok | output | 1 | `nia_out` valid |

## Verification
Two changes can land on the same state word in one vector: the clear-and-set entry pattern and the suspended-to-special rewrite of the transactional field. Mixing both into the result would show up as a wrong field value. The bench forces that field to 0b10 and 0b11 on random state words, and compares every bit against a reference model. In the same way, the cause encoding can collide with the cleared bits of the saved state word. Trap-kind vectors with several bits set, including all ones, are applied to check that no bit overlaps.

// File: rtl/tentry_pkg.sv
package tentry_pkg;

   localparam int unsigned WORD_W = 64;

   function automatic int unsigned be2le(input int unsigned be_pos);
      return 63 - be_pos;
   endfunction

   function automatic logic [63:0] be_bit(input int unsigned be_pos);
      return 64'd1 << be2le(be_pos);
   endfunction

   // state-word fields, big-endian numbering
   localparam int unsigned SW_WIDE   = 0;
   localparam int unsigned SW_HYP    = 3;
   localparam int unsigned SW_UNDEF  = 5;
   localparam int unsigned SW_TXON   = 31;
   localparam int unsigned SW_TXS_HI = 29;
   localparam int unsigned SW_TXS_LO = 30;
   localparam int unsigned SW_VECU   = 38;
   localparam int unsigned SW_VSXU   = 40;
   localparam int unsigned SW_EXTI   = 48;
   localparam int unsigned SW_USER   = 49;
   localparam int unsigned SW_FPU    = 50;
   localparam int unsigned SW_FEX0   = 52;
   localparam int unsigned SW_TRC_HI = 53;
   localparam int unsigned SW_TRC_LO = 54;
   localparam int unsigned SW_FEX1   = 55;
   localparam int unsigned SW_IXLT   = 58;
   localparam int unsigned SW_DXLT   = 59;
   localparam int unsigned SW_PMON   = 61;
   localparam int unsigned SW_RCVR   = 62;
   localparam int unsigned SW_LEND   = 63;

   // program-check cause bits in the saved state word
   localparam int unsigned CZ_TXBAD = 42;
   localparam int unsigned CZ_FLT   = 43;
   localparam int unsigned CZ_ILL   = 44;
   localparam int unsigned CZ_PRIV  = 45;
   localparam int unsigned CZ_TRAP  = 46;
   localparam int unsigned CZ_ADDR  = 47;

   function automatic logic [63:0] be_range(input int unsigned lo_be, input int unsigned hi_be);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = lo_be; i <= hi_be; i++) m |= be_bit(i);
      return m;
   endfunction

   localparam logic [63:0] ENTRY_CLR =
      be_bit(SW_IXLT) | be_bit(SW_DXLT) | be_bit(SW_FEX0) | be_bit(SW_FEX1) |
      be_bit(SW_EXTI) | be_bit(SW_RCVR) | be_bit(SW_TXON) | be_bit(SW_VECU) |
      be_bit(SW_VSXU) | be_bit(SW_USER) | be_bit(SW_FPU)  | be_bit(SW_PMON) |
      be_range(SW_TRC_HI, SW_TRC_LO) | be_bit(SW_UNDEF);

   localparam logic [63:0] ENTRY_SET = be_bit(SW_WIDE) | be_bit(SW_LEND);

   localparam logic [63:0] TRAP_SAVE_CLR = be_range(32, 35);
   localparam logic [63:0] SC_SAVE_CLR   = be_range(33, 36) | be_range(42, 47);

endpackage

// File: rtl/tentry_msr_mask.sv
module tentry_msr_mask
   import tentry_pkg::*;
#(
   parameter int unsigned LVL_W = 7
) (
   input  logic [63:0]      msr_in,
   input  logic             is_sc,
   input  logic [LVL_W-1:0] sc_level,
   output logic [63:0]      msr_new
);

   localparam int unsigned TXS_MSB = be2le(SW_TXS_HI);
   localparam int unsigned TXS_LSB = be2le(SW_TXS_LO);
   localparam int unsigned HYP_LE  = be2le(SW_HYP);

   logic [63:0] masked;
   logic [1:0]  txs_old;
   logic [1:0]  txs_new;
   logic        hyp_new;

   generate
      for (genvar b = 0; b < 64; b++) begin : g_bit
         if (ENTRY_SET[b]) begin : g_set
            assign masked[b] = 1'b1;
         end else if (ENTRY_CLR[b]) begin : g_clr
            assign masked[b] = 1'b0;
         end else begin : g_keep
            assign masked[b] = msr_in[b];
         end
      end
   endgenerate

   assign txs_old = msr_in[TXS_MSB:TXS_LSB];
   assign txs_new = (txs_old == 2'b10) ? 2'b01 : txs_old;
   assign hyp_new = is_sc ? (sc_level == LVL_W'(1)) : msr_in[HYP_LE];

   always_comb begin
      msr_new                  = masked;
      msr_new[TXS_MSB:TXS_LSB] = txs_new;
      msr_new[HYP_LE]          = hyp_new;
   end

endmodule

// File: rtl/tentry_srr1_build.sv
module tentry_srr1_build
   import tentry_pkg::*;
#(
   parameter int unsigned KIND_W = 5
) (
   input  logic [63:0]       msr_in,
   input  logic              is_sc,
   input  logic [KIND_W-1:0] trap_kind,
   output logic [63:0]       srr1_new
);

   logic [63:0] trap_word;
   logic [63:0] sc_word;
   logic        unused_kind_mid;

   assign unused_kind_mid = trap_kind[2];

   always_comb begin
      trap_word = msr_in & ~TRAP_SAVE_CLR;
      trap_word[be2le(CZ_TRAP)]  = (trap_kind == '0);
      trap_word[be2le(CZ_PRIV)]  = trap_kind[1];
      trap_word[be2le(CZ_FLT)]   = trap_kind[0];
      trap_word[be2le(CZ_ADDR)]  = trap_kind[3];
      trap_word[be2le(CZ_ILL)]   = trap_kind[4];
      trap_word[be2le(CZ_TXBAD)] = 1'b0;
   end

   assign sc_word  = msr_in & ~SC_SAVE_CLR;
   assign srr1_new = is_sc ? sc_word : trap_word;

endmodule

// File: rtl/tentry_target.sv
module tentry_target #(
   parameter int unsigned          VEC_W    = 12,
   parameter int unsigned          VEC_SHL  = 4,
   parameter int unsigned          STEP     = 4,
   parameter logic [63:0]          SC_ENTRY = 64'hC00
) (
   input  logic [63:0]      cia_in,
   input  logic             is_sc,
   input  logic [VEC_W-1:0] trap_vec,
   output logic [63:0]      srr0_new,
   output logic [63:0]      nia_new
);

   localparam int unsigned PAD_W = 64 - VEC_W - VEC_SHL;

   logic [63:0] trap_nia;

   generate
      if (PAD_W == 0) begin : g_full
         assign trap_nia = {trap_vec, {VEC_SHL{1'b0}}};
      end else begin : g_pad
         assign trap_nia = {{PAD_W{1'b0}}, trap_vec, {VEC_SHL{1'b0}}};
      end
   endgenerate

   assign srr0_new = is_sc ? (cia_in + 64'(STEP)) : cia_in;
   assign nia_new  = is_sc ? SC_ENTRY : trap_nia;

endmodule

// File: rtl/trap_entry_update.sv
module trap_entry_update #(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned KIND_W   = 5,
   parameter int unsigned LVL_W    = 7,
   parameter int unsigned VEC_W    = 12,
   parameter int unsigned VEC_SHL  = 4,
   parameter int unsigned STEP     = 4,
   parameter logic [63:0] SC_ENTRY = 64'hC00
) (
   input  logic              op_valid,
   input  logic              op_is_sc,
   input  logic [63:0]       msr_in,
   input  logic [63:0]       cia_in,
   input  logic [KIND_W-1:0] trap_kind,
   input  logic [VEC_W-1:0]  trap_vec,
   input  logic [LVL_W-1:0]  sc_level,
   output logic [63:0]       msr_out,
   output logic              msr_ok,
   output logic [63:0]       srr0_out,
   output logic              srr0_ok,
   output logic [63:0]       srr1_out,
   output logic              srr1_ok,
   output logic [63:0]       nia_out,
   output logic              nia_ok
);

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("trap_entry_update: field positions assume a 64-bit word");
      end
      if (KIND_W != 5) begin : g_bad_kind
         $error("trap_entry_update: trap kind vector must be 5 bits");
      end
      if (VEC_W + VEC_SHL > 64) begin : g_bad_vec
         $error("trap_entry_update: shifted vector exceeds the word");
      end
      if (LVL_W == 0) begin : g_bad_lvl
         $error("trap_entry_update: level field needs at least one bit");
      end
   endgenerate

   tentry_msr_mask #(.LVL_W(LVL_W)) u_msr (
      .msr_in  (msr_in),
      .is_sc   (op_is_sc),
      .sc_level(sc_level),
      .msr_new (msr_out)
   );

   tentry_srr1_build #(.KIND_W(KIND_W)) u_srr1 (
      .msr_in   (msr_in),
      .is_sc    (op_is_sc),
      .trap_kind(trap_kind),
      .srr1_new (srr1_out)
   );

   tentry_target #(
      .VEC_W   (VEC_W),
      .VEC_SHL (VEC_SHL),
      .STEP    (STEP),
      .SC_ENTRY(SC_ENTRY)
   ) u_tgt (
      .cia_in  (cia_in),
      .is_sc   (op_is_sc),
      .trap_vec(trap_vec),
      .srr0_new(srr0_out),
      .nia_new (nia_out)
   );

   assign msr_ok  = op_valid;
   assign srr0_ok = op_valid;
   assign srr1_ok = op_valid;
   assign nia_ok  = op_valid;

endmodule

// File: rtl/trap_entry_update_chk.sv
module trap_entry_update_chk #(
   parameter int unsigned VEC_W = 12
) (
   input logic             op_valid,
   input logic             op_is_sc,
   input logic [63:0]      msr_in,
   input logic [63:0]      cia_in,
   input logic [4:0]       trap_kind,
   input logic [VEC_W-1:0] trap_vec,
   input logic [63:0]      msr_out,
   input logic             msr_ok,
   input logic [63:0]      srr0_out,
   input logic             srr0_ok,
   input logic [63:0]      srr1_out,
   input logic             srr1_ok,
   input logic [63:0]      nia_ok_word,
   input logic             nia_ok
);

   logic known;
   logic unused_chk;

   assign known      = !$isunknown({op_valid, op_is_sc, msr_in, cia_in, trap_kind});
   assign unused_chk = ^{trap_vec, nia_ok_word};

   always_comb begin
      if (known) begin
         if (!op_valid) begin
            a_r1_flags_low: assert ({msr_ok, srr0_ok, srr1_ok, nia_ok} == 4'b0000)
               else $error("R1 flag high without entry");
         end else begin
            a_r2_flags_high: assert ({msr_ok, srr0_ok, srr1_ok, nia_ok} == 4'b1111)
               else $error("R2 flag low on entry");
            a_r3_wide_le_set: assert (msr_out[63] && msr_out[0])
               else $error("R3 set bits missing");
            a_r3_ee_pr_clear: assert (!msr_out[15] && !msr_out[14] && !msr_out[5] && !msr_out[4])
               else $error("R3 clear bits present");
            a_r4_ts_susp: assert (msr_in[34:33] != 2'b10 || msr_out[34:33] == 2'b01)
               else $error("R4 suspended field not rewritten");
            a_r4_ts_keep: assert (msr_in[34:33] == 2'b10 || msr_out[34:33] == msr_in[34:33])
               else $error("R4 field altered");
            if (!op_is_sc) begin
               a_r5_trap_srr0: assert (srr0_out == cia_in)
                  else $error("R5 trap save address");
               a_r6_trap_hi: assert (srr1_out[63:32] == msr_in[63:32])
                  else $error("R6 upper saved word");
            end else begin
               a_r5_sc_srr0: assert (srr0_out == cia_in + 64'd4)
                  else $error("R5 call save address");
               a_r8_sc_clear: assert (srr1_out[30:27] == 4'b0 && srr1_out[21:16] == 6'b0)
                  else $error("R8 call save clears");
            end
         end
      end
   end

endmodule

bind trap_entry_update trap_entry_update_chk #(.VEC_W(VEC_W)) u_chk (
   .op_valid   (op_valid),
   .op_is_sc   (op_is_sc),
   .msr_in     (msr_in),
   .cia_in     (cia_in),
   .trap_kind  (trap_kind),
   .trap_vec   (trap_vec),
   .msr_out    (msr_out),
   .msr_ok     (msr_ok),
   .srr0_out   (srr0_out),
   .srr0_ok    (srr0_ok),
   .srr1_out   (srr1_out),
   .srr1_ok    (srr1_ok),
   .nia_ok_word(nia_out),
   .nia_ok     (nia_ok)
);

// File: tb/tb_trap_entry_update.sv
module tb_trap_entry_update;

   localparam int CLK_PERIOD = 10;
   localparam int VW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          op_valid, op_is_sc;
   logic [63:0]   msr_in, cia_in;
   logic [4:0]    trap_kind;
   logic [VW-1:0] trap_vec;
   logic [6:0]    sc_level;
   logic [63:0]   msr_out, srr0_out, srr1_out, nia_out;
   logic          msr_ok, srr0_ok, srr1_ok, nia_ok;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   trap_entry_update dut (
      .op_valid(op_valid), .op_is_sc(op_is_sc), .msr_in(msr_in), .cia_in(cia_in),
      .trap_kind(trap_kind), .trap_vec(trap_vec), .sc_level(sc_level),
      .msr_out(msr_out), .msr_ok(msr_ok), .srr0_out(srr0_out), .srr0_ok(srr0_ok),
      .srr1_out(srr1_out), .srr1_ok(srr1_ok), .nia_out(nia_out), .nia_ok(nia_ok)
   );

   // reference models written from the requirements (LSB-0 indices)
   function automatic logic [63:0] ref_msr(logic [63:0] m, logic sc, logic [6:0] lvl);
      logic [63:0] r;
      r = m;
      r[5] = 0; r[4] = 0; r[11] = 0; r[8] = 0; r[15] = 0; r[1] = 0; r[32] = 0;   // R3
      r[25] = 0; r[23] = 0; r[14] = 0; r[13] = 0; r[2] = 0; r[10] = 0; r[9] = 0;
      r[58] = 0;
      r[63] = 1; r[0] = 1;
      if (m[34:33] == 2'b10) r[34:33] = 2'b01;                                       // R4
      if (sc) r[60] = (lvl == 7'd1);                                                 // R9
      return r;
   endfunction

   function automatic logic [63:0] ref_srr1(logic [63:0] m, logic sc, logic [4:0] k);
      logic [63:0] r;
      r = m;
      if (sc) begin                                                                  // R8
         r[30:27] = 4'b0;
         r[21:16] = 6'b0;
      end else begin                                                                 // R6
         r[31:28] = 4'b0;
         r[17] = (k == 5'd0);
         r[18] = k[1];
         r[20] = k[0];
         r[16] = k[3];
         r[19] = k[4];
         r[21] = 1'b0;
      end
      return r;
   endfunction

   task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic v, input logic sc, input logic [63:0] m,
                        input logic [63:0] pc, input logic [4:0] k,
                        input logic [VW-1:0] vec, input logic [6:0] lvl);
      logic [63:0] e_nia;
      @(negedge clk);
      op_valid = v; op_is_sc = sc; msr_in = m; cia_in = pc;
      trap_kind = k; trap_vec = vec; sc_level = lvl;
      #1;
      n_vec++;
      if (!v) begin
         cmp("R1 flags", 64'({msr_ok, srr0_ok, srr1_ok, nia_ok}), 64'd0);
      end else begin
         e_nia = sc ? 64'hC00 : (64'(vec) << 4);
         cmp("R2 flags", 64'({msr_ok, srr0_ok, srr1_ok, nia_ok}), 64'hF);
         cmp("R3 R4 R9 msr", msr_out, ref_msr(m, sc, lvl));
         cmp("R5 srr0", srr0_out, sc ? pc + 64'd4 : pc);
         cmp(sc ? "R8 srr1" : "R6 srr1", srr1_out, ref_srr1(m, sc, k));
         cmp(sc ? "R10 nia" : "R7 nia", nia_out, e_nia);
      end
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      op_valid = 0; op_is_sc = 0; msr_in = '0; cia_in = '0;
      trap_kind = '0; trap_vec = '0; sc_level = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: idle state, including after reset
      apply(0, 0, rnd64(), rnd64(), 5'h1F, 12'hFFF, 7'd1);
      apply(0, 1, '1, '1, 5'h0, 12'h0, 7'd1);
      // R3: all-zero and all-one state words
      apply(1, 0, 64'd0, 64'h100, 5'd0, 12'h0, 7'd0);
      apply(1, 0, '1, 64'h200, 5'h1F, 12'hFFF, 7'd0);
      // R4: suspended field vs other values
      apply(1, 0, 64'h0000_0004_0000_0000, 64'h300, 5'd2, 12'h7, 7'd0);
      apply(1, 1, 64'h0000_0006_0000_0000, 64'h400, 5'd0, 12'h7, 7'd0);
      apply(1, 1, 64'h0000_0002_0000_0000, 64'h400, 5'd0, 12'h7, 7'd1);
      // R5: address wrap on system call
      apply(1, 1, rnd64(), 64'hFFFF_FFFF_FFFF_FFFC, 5'd0, 12'h0, 7'd1);
      apply(1, 1, rnd64(), 64'hFFFF_FFFF_FFFF_FFFE, 5'd0, 12'h0, 7'd2);
      // R6: each trap kind bit alone; bit 2 has no effect
      for (int i = 0; i < 5; i++) apply(1, 0, rnd64(), rnd64(), 5'(1 << i), 12'h55, 7'd0);
      // R7: extreme vectors
      apply(1, 0, rnd64(), rnd64(), 5'd0, 12'hFFF, 7'd0);
      apply(1, 0, rnd64(), rnd64(), 5'd0, 12'h001, 7'd0);
      // R9: level 0, 1, 2, max with hypervisor bit both ways
      apply(1, 1, 64'd0, 64'h10, 5'd0, 12'h0, 7'd1);
      apply(1, 1, '1, 64'h10, 5'd0, 12'h0, 7'd0);
      apply(1, 1, '1, 64'h10, 5'd0, 12'h0, 7'd2);
      apply(1, 1, 64'd0, 64'h10, 5'd0, 12'h0, 7'h7F);
      // random mix (R2 R3 R4 R6 R8 R10)
      for (int i = 0; i < 400; i++) begin
         logic [63:0] m;
         m = rnd64();
         if ($urandom_range(0, 3) == 0) m[34:33] = 2'b10;
         apply($urandom_range(0, 7) != 0, 1'($urandom()), m, rnd64(),
               5'($urandom()), VW'($urandom()), ($urandom_range(0, 2) == 0) ? 7'd1 : 7'($urandom()));
      end
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule